// File: doc/BRIEF.md
# Priority Pin Crossbar Decoder

This block places a fixed, ranked list of peripheral signals onto a row of general-purpose port pins. Each signal that is switched on takes the lowest pin that is still free. A pin counts as taken once an earlier signal holds it, or when its skip bit is set. The asynchronous serial transmit and receive pair is the one exception. Whenever that interface is enabled, the pair sits at pins 4 and 5. The skip mask does not move it, and lower free pins do not move it either.

The configuration comes in as enable bits for each peripheral group, a serial-peripheral 4-wire mode bit, a count of active capture/compare outputs, a skip bit for each pin and a package-select bit. A combinational allocation chain works out the assignment, and registers capture it on every clock edge. The block reports three things. For each pin it gives the code of the signal that drives it. For each signal it gives the pin index and an assigned flag. It also gives one overflow flag.

Pins are indexed 0 to 16. Port 0 bits map to 0–7, port 1 bits to 8–15, and port 2 bit 0 to 16.

Top module: `prio_xbar`

## Requirements
- R1: While rst_n is low, every pin code, every signal pin index, every assigned flag and the overflow flag are zero.
- R2: Signals are placed in this order: uart tx, uart rx, spi clock, spi master-in, spi master-out, spi select, smbus data, smbus clock, comparator sync, comparator async, system clock, CEX0..CEX(PCA_CH-1), counter input, timer0 input, timer1 input. Each enabled signal other than the uart pair takes the lowest pin index that is neither skipped nor already held.
- R3: With uart_en_i high, uart tx is assigned to pin 4 and uart rx to pin 5, whatever skip_i holds. No other signal ever lands on pins 4 or 5 in that case, even when lower pins are free.
- R4: A pin whose skip_i bit is set never carries a signal, except pins 4 and 5 while the uart is enabled.
- R5: The spi select signal is requested only when spi_en_i and spi_4wire_i are both high. Otherwise it is unassigned and uses no pin.
- R6: With small_pkg_i high, pin 16 is never assigned.
- R7: An enabled signal that finds no free pin has its assigned flag low and its pin index 0, and overflow_o goes high. Later signals are still processed against the same remaining pins.
- R8: Pin code 0 means plain GPIO. Signal k in the R2 order (counting from 0) is reported with code k+1 in 5-bit fields, with pin p at pin_sel_o[5p+4:5p] and the pin of signal k at sig_pin_o[5k+4:5k].
- R9: Outputs reflect a configuration change after exactly one rising clock edge, and not before it.
- R10: CEXn is requested exactly when cex_count_i is greater than n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| small_pkg_i | input | 1 | Removes the top pin (index 16) from the candidate set |
| uart_en_i | input | 1 | Enables the uart tx/rx pair |
| spi_en_i | input | 1 | Enables spi clock, master-in, master-out |
| spi_4wire_i | input | 1 | Also requests spi select when spi is enabled |
| smbus_en_i | input | 1 | Enables smbus data and clock |
| cmp_en_i | input | 1 | Enables comparator synchronous output |
| cmp_async_en_i | input | 1 | Enables comparator asynchronous output |
| sysclk_en_i | input | 1 | Enables system clock output |
| cex_count_i | input | 2 | Number of capture/compare outputs enabled |
| eci_en_i | input | 1 | Enables counter external clock input |
| t0_en_i | input | 1 | Enables timer0 input |
| t1_en_i | input | 1 | Enables timer1 input |
| skip_i | input | 17 | Pins the crossbar must pass over |
| pin_sel_o | output | 85 | Per-pin signal code, 5 bits per pin |
| sig_pin_o | output | 85 | Per-signal pin index, 5 bits per signal |
| sig_valid_o | output | 17 | Per-signal assigned flag |
| overflow_o | output | 1 | Some enabled signal found no pin |

## Verification
The bench builds the block with its defaults: 17 pins and three capture/compare channels. At that size every signal and every pin position can be observed. Thousands of random configurations are applied. About half of them use a dense skip mask, which drives the chain into overflow, and the rest use a sparse one, which exercises long placement runs. Every capture/compare count and both package options are covered. Directed cases pin down the uart pair on skipped pins, 3-wire spi, and the excluded top pin.

// File: rtl/prio_xbar_pkg.sv
package prio_xbar_pkg;
  // Fixed ranks of the signals in placement order
  localparam int SIG_TX     = 0;
  localparam int SIG_RX     = 1;
  localparam int SIG_SCK    = 2;
  localparam int SIG_MISO   = 3;
  localparam int SIG_MOSI   = 4;
  localparam int SIG_NSEL   = 5;
  localparam int SIG_SDA    = 6;
  localparam int SIG_SCL    = 7;
  localparam int SIG_CMP    = 8;
  localparam int SIG_CMPA   = 9;
  localparam int SIG_SYSCLK = 10;
  localparam int SIG_CEX0   = 11;

  function automatic int sig_count(input int pca_ch);
    return SIG_CEX0 + pca_ch + 3;
  endfunction
endpackage

// File: rtl/xbar_request.sv
module xbar_request
  import prio_xbar_pkg::*;
#(
  parameter int PCA_CH = 3,
  parameter int NSIG   = sig_count(PCA_CH),
  parameter int CEXW   = $clog2(PCA_CH + 1)
) (
  input  logic            uart_en_i,
  input  logic            spi_en_i,
  input  logic            spi_4wire_i,
  input  logic            smbus_en_i,
  input  logic            cmp_en_i,
  input  logic            cmp_async_en_i,
  input  logic            sysclk_en_i,
  input  logic [CEXW-1:0] cex_count_i,
  input  logic            eci_en_i,
  input  logic            t0_en_i,
  input  logic            t1_en_i,
  output logic [NSIG-1:0] req_o
);
  localparam int SIG_ECI = SIG_CEX0 + PCA_CH;

  logic [PCA_CH-1:0] cex_req;

  for (genvar c = 0; c < PCA_CH; c++) begin : g_cex
    assign cex_req[c] = ({1'b0, cex_count_i} > (CEXW+1)'(c));
  end

  always_comb begin
    req_o             = '0;
    req_o[SIG_TX]     = uart_en_i;
    req_o[SIG_RX]     = uart_en_i;
    req_o[SIG_SCK]    = spi_en_i;
    req_o[SIG_MISO]   = spi_en_i;
    req_o[SIG_MOSI]   = spi_en_i;
    req_o[SIG_NSEL]   = spi_en_i & spi_4wire_i;
    req_o[SIG_SDA]    = smbus_en_i;
    req_o[SIG_SCL]    = smbus_en_i;
    req_o[SIG_CMP]    = cmp_en_i;
    req_o[SIG_CMPA]   = cmp_async_en_i;
    req_o[SIG_SYSCLK] = sysclk_en_i;
    req_o[SIG_CEX0 +: PCA_CH] = cex_req;
    req_o[SIG_ECI]    = eci_en_i;
    req_o[SIG_ECI+1]  = t0_en_i;
    req_o[SIG_ECI+2]  = t1_en_i;
  end
endmodule

// File: rtl/xbar_slot.sv
module xbar_slot #(
  parameter int NUM_PINS  = 17,
  parameter int PINW      = $clog2(NUM_PINS),
  parameter bit FIXED     = 1'b0,
  parameter int FIXED_PIN = 0
) (
  input  logic [NUM_PINS-1:0] taken_i,
  input  logic                req_i,
  output logic                hit_o,
  output logic [PINW-1:0]     pin_o,
  output logic [NUM_PINS-1:0] taken_o
);
  if (FIXED) begin : g_fixed
    // Position reserved up front in the initial taken mask
    assign hit_o   = req_i;
    assign pin_o   = req_i ? PINW'(FIXED_PIN) : '0;
    assign taken_o = taken_i;
  end else begin : g_search
    logic            free_any;
    logic [PINW-1:0] free_pin;

    always_comb begin
      free_any = 1'b0;
      free_pin = '0;
      for (int p = NUM_PINS - 1; p >= 0; p--) begin
        if (!taken_i[p]) begin
          free_any = 1'b1;
          free_pin = PINW'(p);
        end
      end
    end

    assign hit_o = req_i & free_any;
    assign pin_o = hit_o ? free_pin : '0;

    always_comb begin
      taken_o = taken_i;
      if (hit_o) taken_o[free_pin] = 1'b1;
    end
  end
endmodule

// File: rtl/xbar_encode.sv
module xbar_encode #(
  parameter int NUM_PINS = 17,
  parameter int NSIG     = 17,
  parameter int PINW     = $clog2(NUM_PINS),
  parameter int SELW     = $clog2(NSIG + 1)
) (
  input  logic [NSIG-1:0]          hit_i,
  input  logic [NSIG*PINW-1:0]     pin_i,
  output logic [NUM_PINS*SELW-1:0] sel_o
);
  // Pins held by distinct signals, so OR-merging codes is exact
  always_comb begin
    sel_o = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      for (int s = 0; s < NSIG; s++) begin
        if (hit_i[s] && (pin_i[s*PINW +: PINW] == PINW'(p)))
          sel_o[p*SELW +: SELW] = sel_o[p*SELW +: SELW] | SELW'(s + 1);
      end
    end
  end
endmodule

// File: rtl/prio_xbar.sv
module prio_xbar
  import prio_xbar_pkg::*;
#(
  parameter int NUM_PINS = 17,
  parameter int PCA_CH   = 3,
  parameter int TX_PIN   = 4,
  parameter int RX_PIN   = 5,
  parameter int NSIG     = sig_count(PCA_CH),
  parameter int PINW     = $clog2(NUM_PINS),
  parameter int SELW     = $clog2(NSIG + 1),
  parameter int CEXW     = $clog2(PCA_CH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     small_pkg_i,
  input  logic                     uart_en_i,
  input  logic                     spi_en_i,
  input  logic                     spi_4wire_i,
  input  logic                     smbus_en_i,
  input  logic                     cmp_en_i,
  input  logic                     cmp_async_en_i,
  input  logic                     sysclk_en_i,
  input  logic [CEXW-1:0]          cex_count_i,
  input  logic                     eci_en_i,
  input  logic                     t0_en_i,
  input  logic                     t1_en_i,
  input  logic [NUM_PINS-1:0]      skip_i,
  output logic [NUM_PINS*SELW-1:0] pin_sel_o,
  output logic [NSIG*PINW-1:0]     sig_pin_o,
  output logic [NSIG-1:0]          sig_valid_o,
  output logic                     overflow_o
);
  localparam int TOP_PIN = NUM_PINS - 1;

  logic [NSIG-1:0]          req;
  logic [NSIG-1:0]          hit;
  logic [NSIG*PINW-1:0]     pin_flat;
  logic [NUM_PINS-1:0]      taken [NSIG+1];
  logic [NUM_PINS*SELW-1:0] sel_nxt;
  logic                     ovf_nxt;

  xbar_request #(.PCA_CH(PCA_CH), .NSIG(NSIG), .CEXW(CEXW)) i_request (
    .uart_en_i      (uart_en_i),
    .spi_en_i       (spi_en_i),
    .spi_4wire_i    (spi_4wire_i),
    .smbus_en_i     (smbus_en_i),
    .cmp_en_i       (cmp_en_i),
    .cmp_async_en_i (cmp_async_en_i),
    .sysclk_en_i    (sysclk_en_i),
    .cex_count_i    (cex_count_i),
    .eci_en_i       (eci_en_i),
    .t0_en_i        (t0_en_i),
    .t1_en_i        (t1_en_i),
    .req_o          (req)
  );

  // Initial occupancy: skip mask, package cut, uart reservation
  always_comb begin
    taken[0] = skip_i;
    if (small_pkg_i) taken[0][TOP_PIN] = 1'b1;
    if (uart_en_i) begin
      taken[0][TX_PIN] = 1'b1;
      taken[0][RX_PIN] = 1'b1;
    end
  end

  for (genvar s = 0; s < NSIG; s++) begin : g_slot
    localparam bit IS_FIXED = (s == SIG_TX) || (s == SIG_RX);
    localparam int FPIN     = (s == SIG_TX) ? TX_PIN : RX_PIN;
    xbar_slot #(
      .NUM_PINS(NUM_PINS), .PINW(PINW), .FIXED(IS_FIXED), .FIXED_PIN(FPIN)
    ) i_slot (
      .taken_i (taken[s]),
      .req_i   (req[s]),
      .hit_o   (hit[s]),
      .pin_o   (pin_flat[s*PINW +: PINW]),
      .taken_o (taken[s+1])
    );
  end

  xbar_encode #(
    .NUM_PINS(NUM_PINS), .NSIG(NSIG), .PINW(PINW), .SELW(SELW)
  ) i_encode (
    .hit_i (hit),
    .pin_i (pin_flat),
    .sel_o (sel_nxt)
  );

  assign ovf_nxt = |(req & ~hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sel_o   <= '0;
      sig_pin_o   <= '0;
      sig_valid_o <= '0;
      overflow_o  <= 1'b0;
    end else begin
      pin_sel_o   <= sel_nxt;
      sig_pin_o   <= pin_flat;
      sig_valid_o <= hit;
      overflow_o  <= ovf_nxt;
    end
  end
endmodule

// File: rtl/prio_xbar_chk.sv
module prio_xbar_chk #(
  parameter int NUM_PINS = 17,
  parameter int NSIG     = 17,
  parameter int PINW     = 5,
  parameter int SELW     = 5,
  parameter int TX_PIN   = 4,
  parameter int RX_PIN   = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     small_pkg_i,
  input logic                     uart_en_i,
  input logic                     spi_4wire_i,
  input logic [NUM_PINS-1:0]      skip_i,
  input logic [NUM_PINS*SELW-1:0] pin_sel_o,
  input logic [NSIG*PINW-1:0]     sig_pin_o,
  input logic [NSIG-1:0]          sig_valid_o,
  input logic                     overflow_o
);
  logic                started;
  logic [NUM_PINS-1:0] occ;
  logic [NUM_PINS-1:0] uart_mask;
  logic [NUM_PINS-1:0] top_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) occ[p] = |pin_sel_o[p*SELW +: SELW];
    uart_mask = '0;
    uart_mask[TX_PIN] = 1'b1;
    uart_mask[RX_PIN] = 1'b1;
    top_mask = '0;
    top_mask[NUM_PINS-1] = 1'b1;
  end

  AST_UART_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(uart_en_i) |-> sig_valid_o[0] && sig_valid_o[1] &&
      sig_pin_o[0 +: PINW] == PINW'(TX_PIN) &&
      sig_pin_o[PINW +: PINW] == PINW'(RX_PIN)); // R3

  AST_SKIP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (occ & $past(skip_i) &
      ~($past(uart_en_i) ? uart_mask : '0)) == '0); // R4

  AST_NSEL_3WIRE: assert property (@(posedge clk) disable iff (!rst_n)
    started && !$past(spi_4wire_i) |-> !sig_valid_o[5]); // R5

  AST_TOP_PIN_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(small_pkg_i) |-> !occ[NUM_PINS-1]); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    started && overflow_o |-> &(occ | $past(skip_i) |
      ($past(small_pkg_i) ? top_mask : '0))); // R7

  AST_ONE_PIN_EACH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(occ) == $countones(sig_valid_o)); // R8
endmodule

bind prio_xbar prio_xbar_chk #(
  .NUM_PINS(NUM_PINS), .NSIG(NSIG), .PINW(PINW), .SELW(SELW),
  .TX_PIN(TX_PIN), .RX_PIN(RX_PIN)
) i_prio_xbar_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .small_pkg_i (small_pkg_i),
  .uart_en_i   (uart_en_i),
  .spi_4wire_i (spi_4wire_i),
  .skip_i      (skip_i),
  .pin_sel_o   (pin_sel_o),
  .sig_pin_o   (sig_pin_o),
  .sig_valid_o (sig_valid_o),
  .overflow_o  (overflow_o)
);

// File: tb/test_prio_xbar.sv
module test_prio_xbar;
  localparam int NP = 17;
  localparam int NS = 17;
  localparam int W  = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic small_pkg, uart_en, spi_en, spi_4w, smb_en, cmp_en, cmpa_en, sck_en;
  logic [1:0] cex_cnt;
  logic eci_en, t0_en, t1_en;
  logic [NP-1:0]   skip;
  logic [NP*W-1:0] pin_sel;
  logic [NS*W-1:0] sig_pin;
  logic [NS-1:0]   sig_val;
  logic            ovf;

  logic [NP*W-1:0] exp_sel;
  logic [NS*W-1:0] exp_pin;
  logic [NS-1:0]   exp_val;
  logic            exp_ovf;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  prio_xbar i_prio_xbar (
    .clk(clk), .rst_n(rst_n), .small_pkg_i(small_pkg), .uart_en_i(uart_en),
    .spi_en_i(spi_en), .spi_4wire_i(spi_4w), .smbus_en_i(smb_en),
    .cmp_en_i(cmp_en), .cmp_async_en_i(cmpa_en), .sysclk_en_i(sck_en),
    .cex_count_i(cex_cnt), .eci_en_i(eci_en), .t0_en_i(t0_en), .t1_en_i(t1_en),
    .skip_i(skip), .pin_sel_o(pin_sel), .sig_pin_o(sig_pin),
    .sig_valid_o(sig_val), .overflow_o(ovf)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected result from the placement rules (R2..R8, R10)
  task automatic compute();
    logic [NP-1:0] tk;
    logic [NS-1:0] rq;
    rq = '0;
    rq[0] = uart_en; rq[1] = uart_en;
    rq[2] = spi_en;  rq[3] = spi_en; rq[4] = spi_en;
    rq[5] = spi_en & spi_4w;
    rq[6] = smb_en;  rq[7] = smb_en;
    rq[8] = cmp_en;  rq[9] = cmpa_en; rq[10] = sck_en;
    for (int c = 0; c < 3; c++) rq[11+c] = (int'(cex_cnt) > c);
    rq[14] = eci_en; rq[15] = t0_en; rq[16] = t1_en;
    tk = skip;
    if (small_pkg) tk[16] = 1'b1;
    if (uart_en) begin tk[4] = 1'b1; tk[5] = 1'b1; end
    exp_sel = '0; exp_pin = '0; exp_val = '0; exp_ovf = 1'b0;
    for (int s = 0; s < NS; s++) begin
      if (rq[s]) begin
        int p;
        p = -1;
        if (s == 0) p = 4;
        else if (s == 1) p = 5;
        else begin
          for (int q = 0; q < NP; q++) if (p < 0 && !tk[q]) p = q;
        end
        if (p >= 0) begin
          tk[p] = 1'b1;
          exp_val[s] = 1'b1;
          exp_pin[s*W +: W] = W'(p);
          exp_sel[p*W +: W] = W'(s + 1);
        end else exp_ovf = 1'b1;
      end
    end
  endtask

  task automatic compare(input string req);
    check(pin_sel == exp_sel, req, "pin codes", 128'(pin_sel), 128'(exp_sel));
    check(sig_pin == exp_pin, req, "signal pins", 128'(sig_pin), 128'(exp_pin));
    check(sig_val == exp_val, req, "assigned flags", 128'(sig_val), 128'(exp_val));
    check(ovf == exp_ovf, req, "overflow", 128'(ovf), 128'(exp_ovf));
  endtask

  task automatic clear_cfg();
    {small_pkg, uart_en, spi_en, spi_4w, smb_en, cmp_en, cmpa_en, sck_en} = '0;
    {eci_en, t0_en, t1_en} = '0;
    cex_cnt = '0;
    skip = '0;
  endtask

  task automatic all_on();
    {uart_en, spi_en, spi_4w, smb_en, cmp_en, cmpa_en, sck_en} = '1;
    {eci_en, t0_en, t1_en} = '1;
    cex_cnt = 2'd3;
  endtask

  // Inputs already driven at a falling edge: wait one edge, then compare
  task automatic settle(input string req);
    @(negedge clk);
    compute();
    compare(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    clear_cfg();
    all_on();
    repeat (3) @(negedge clk);
    check(pin_sel == '0 && sig_pin == '0 && sig_val == '0 && ovf == 1'b0,
          "R1", "reset state", 128'({sig_val, ovf}), 128'(0));
    rst_n = 1'b1;

    // R2 R3: everything enabled, no skip; uart pair reserved first
    settle("R2");
    check(sig_pin[2*W +: W] == 5'd0 && sig_pin[6*W +: W] == 5'd6, "R3",
          "sck at 0, sda passes 4/5", 128'(sig_pin[6*W +: W]), 128'(6));

    // R3: uart on fully skipped port still lands on 4 and 5
    @(negedge clk); skip = '1;
    settle("R3");
    check(sig_val == 17'h3 && ovf, "R3", "only uart placed",
          128'(sig_val), 128'(3));

    // R5: 3-wire spi leaves select unplaced
    @(negedge clk); clear_cfg(); spi_en = 1'b1; smb_en = 1'b1;
    settle("R5");
    check(!sig_val[5] && sig_pin[6*W +: W] == 5'd3, "R5", "sda follows mosi",
          128'(sig_pin[6*W +: W]), 128'(3));

    // R6 R7: only top pin free
    @(negedge clk); clear_cfg(); skip = 17'h0FFFF; t1_en = 1'b1;
    settle("R6");
    check(sig_pin[16*W +: W] == 5'd16 && sig_val[16], "R6", "top pin used",
          128'(sig_pin[16*W +: W]), 128'(16));
    @(negedge clk); small_pkg = 1'b1;
    settle("R7");
    check(!sig_val[16] && ovf && pin_sel == '0, "R7", "no room overflow",
          128'({sig_val[16], ovf}), 128'(1));

    // R8: single signal code
    @(negedge clk); clear_cfg(); t1_en = 1'b1;
    settle("R8");
    check(pin_sel[0 +: W] == 5'd17, "R8", "timer1 code on pin 0",
          128'(pin_sel[0 +: W]), 128'(17));

    // R10: every capture/compare count
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); clear_cfg(); cex_cnt = 2'(c);
      settle("R10");
    end

    // R9: no change before the edge, change after it
    @(negedge clk); clear_cfg(); cmp_en = 1'b1;
    settle("R9");
    @(negedge clk); clear_cfg(); sck_en = 1'b1;
    #1;
    check(sig_val == 17'h100, "R9", "old result before edge",
          128'(sig_val), 128'(17'h100));
    settle("R9");

    // R2 R4 R7: randomised sweep, dense and sparse skip masks
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      {small_pkg, uart_en, spi_en, spi_4w, smb_en, cmp_en, cmpa_en, sck_en} = 8'($urandom);
      {eci_en, t0_en, t1_en} = 3'($urandom);
      cex_cnt = 2'($urandom);
      if (i % 2 == 0) skip = NP'($urandom) | NP'($urandom);
      else            skip = NP'($urandom) & NP'($urandom) & NP'($urandom);
      settle((i % 2 == 0) ? "R4" : "R2");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule